// File: doc/BRIEF.md
# USB Host Controller Status and Interrupt Register

This unit holds the status word of a USB 1.x-style host controller. The schedule engine and the bus-master interface report events to it as single-cycle pulses: a finished transfer, a failed transfer, a short packet, resume signalling from a device, a fatal descriptor inconsistency and a host bus failure. Each event sets one or more flags. Software reads the word and clears individual flags by writing 1 to them. A 0 in the write data leaves the flag alone.

The unit drives a level-sensitive interrupt request from the flags. Three of the flags are gated by enable inputs, and the two fatal flags always interrupt. While either fatal flag is set, the unit also asks the command register to drop its Run/Stop bit. When Run/Stop goes from 1 to 0 for any reason, the unit records that the controller has halted. The command register, the schedule engine and any wider interrupt masking are outside this unit.

Top module: `usbsts_unit`

## Requirements
- R1: After reset, `sts_word` reads 0x0020 (only the halted flag, bit 5, set), and `irq` and `stop_req` are 0.
- R2: Bits 15 to 6 of `sts_word` read 0 in every state.
- R3: A cycle with `sw_wr`=1 clears each flag in bits 5..0 whose `sw_wdata` bit is 1 and leaves every flag whose `sw_wdata` bit is 0 unchanged. The result is visible one clock later.
- R4: The halted flag (bit 5) sets one clock after a cycle in which `run_stop` is 0 and was 1 in the previous cycle. It does not set while `run_stop` stays at 0.
- R5: A pulse on `ev_proc_err` sets bit 4 one clock later. From then on `stop_req`=1 and `irq`=1, whatever `ien` holds.
- R6: A pulse on `ev_bus_err` sets bit 3 one clock later. From then on `stop_req`=1 and `irq`=1, whatever `ien` holds. `stop_req` is 1 exactly while bit 3 or bit 4 is set.
- R7: A pulse on `ev_resume` sets bit 2 only if `suspend_on`=1 in the same cycle. Otherwise it is ignored.
- R8: A pulse on `ev_xfer_err` sets bit 1. If `td_ioc`=1 in that cycle, it also sets bit 0.
- R9: Bit 0 sets on `ev_xfer_done` with `td_ioc`=1. It also sets on `ev_short_pkt` with `td_spd`=1. `ev_xfer_done` without `td_ioc` and `ev_short_pkt` without `td_spd` have no effect.
- R10: When an event sets a flag in the same cycle that a software write clears it, the flag ends up set.
- R11: `irq` = (bit0 & `ien[0]`) | (bit1 & `ien[1]`) | (bit2 & `ien[2]`) | bit3 | bit4. The halted flag never drives `irq`, and `irq` stays high until the causing flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_xfer_done | input | 1 | Transfer finished pulse |
| ev_xfer_err | input | 1 | Transfer ended in error pulse |
| ev_short_pkt | input | 1 | Short packet received pulse |
| td_ioc | input | 1 | Interrupt-on-complete flag of the descriptor behind the event |
| td_spd | input | 1 | Short-packet-detect flag of the descriptor behind the event |
| ev_resume | input | 1 | Resume signalling seen on the bus |
| ev_proc_err | input | 1 | Fatal descriptor consistency failure pulse |
| ev_bus_err | input | 1 | Host bus access failure pulse |
| run_stop | input | 1 | Current Run/Stop bit of the command register |
| suspend_on | input | 1 | Current global suspend bit of the command register |
| ien | input | 3 | Interrupt enables for bits 0, 1, 2 |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 6 | Write-1-to-clear data for bits 5..0 |
| sts_word | output | 16 | Status word, read by software |
| irq | output | 1 | Level interrupt request |
| stop_req | output | 1 | Request to force Run/Stop to 0 |

## Verification
The bench uses the default 16-bit word with six live flags, so every flag and every reserved bit can be observed through the ports. The transfer-side event inputs and their descriptor sideband flags are swept over all 32 combinations, and bits 0 and 1 are predicted arithmetically for each. The enable vector is swept over all eight values for each gated flag. Same-cycle set and clear collisions are driven on every flag, including the halted flag through a Run/Stop fall.

// File: rtl/usbsts_pkg.sv
package usbsts_pkg;

  localparam int LIVE_W  = 6;
  localparam int B_INT   = 0;
  localparam int B_ERR   = 1;
  localparam int B_RSM   = 2;
  localparam int B_HBE   = 3;
  localparam int B_PERR  = 4;
  localparam int B_HALT  = 5;
  localparam int GATED_W = 3;

  typedef struct packed {
    logic xfer_done;
    logic xfer_err;
    logic short_pkt;
    logic ioc;
    logic spd;
    logic resume;
    logic suspend;
    logic proc_err;
    logic bus_err;
    logic stop_fall;
  } sts_evt_t;

  // Which flags a set of simultaneous events raises.
  function automatic logic [LIVE_W-1:0] set_vector(sts_evt_t e);
    logic [LIVE_W-1:0] v;
    v         = '0;
    v[B_INT]  = (e.xfer_done & e.ioc) | (e.xfer_err & e.ioc) | (e.short_pkt & e.spd);
    v[B_ERR]  = e.xfer_err;
    v[B_RSM]  = e.resume & e.suspend;
    v[B_HBE]  = e.bus_err;
    v[B_PERR] = e.proc_err;
    v[B_HALT] = e.stop_fall;
    return v;
  endfunction

  // Write-1-to-clear update: a set in the same cycle beats the clear.
  function automatic logic w1c_next(logic cur, logic set, logic clr);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/usbsts_evt_decode.sv
module usbsts_evt_decode
  import usbsts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_xfer_done,
  input  logic              ev_xfer_err,
  input  logic              ev_short_pkt,
  input  logic              td_ioc,
  input  logic              td_spd,
  input  logic              ev_resume,
  input  logic              ev_proc_err,
  input  logic              ev_bus_err,
  input  logic              run_stop,
  input  logic              suspend_on,
  output logic              stop_fall,
  output logic [LIVE_W-1:0] set_vec
);

  logic run_stop_q;
  sts_evt_t evt;

  always_ff @(posedge clk) begin
    if (!rst_n) run_stop_q <= 1'b0;
    else        run_stop_q <= run_stop;
  end

  assign stop_fall = run_stop_q & ~run_stop;

  always_comb begin
    evt.xfer_done = ev_xfer_done;
    evt.xfer_err  = ev_xfer_err;
    evt.short_pkt = ev_short_pkt;
    evt.ioc       = td_ioc;
    evt.spd       = td_spd;
    evt.resume    = ev_resume;
    evt.suspend   = suspend_on;
    evt.proc_err  = ev_proc_err;
    evt.bus_err   = ev_bus_err;
    evt.stop_fall = stop_fall;
  end

  assign set_vec = set_vector(evt);

endmodule

// File: rtl/usbsts_w1c_cell.sv
module usbsts_w1c_cell
  import usbsts_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= RST_VAL;
    else        flag_o <= w1c_next(flag_o, set_i, clr_i);
  end

endmodule

// File: rtl/usbsts_irq_merge.sv
module usbsts_irq_merge #(
  parameter int GATED = 3,
  parameter int FORCED = 2
) (
  input  logic [GATED-1:0]  gated_flags,
  input  logic [GATED-1:0]  enables,
  input  logic [FORCED-1:0] forced_flags,
  output logic              irq_o
);

  logic [GATED-1:0] masked;

  for (genvar g = 0; g < GATED; g++) begin : g_mask
    assign masked[g] = gated_flags[g] & enables[g];
  end

  assign irq_o = (|masked) | (|forced_flags);

endmodule

// File: rtl/usbsts_unit.sv
module usbsts_unit
  import usbsts_pkg::*;
#(
  parameter int STS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_xfer_done,
  input  logic               ev_xfer_err,
  input  logic               ev_short_pkt,
  input  logic               td_ioc,
  input  logic               td_spd,
  input  logic               ev_resume,
  input  logic               ev_proc_err,
  input  logic               ev_bus_err,
  input  logic               run_stop,
  input  logic               suspend_on,
  input  logic [GATED_W-1:0] ien,
  input  logic               sw_wr,
  input  logic [LIVE_W-1:0]  sw_wdata,
  output logic [STS_W-1:0]   sts_word,
  output logic               irq,
  output logic               stop_req
);

  localparam int RSV_W = STS_W - LIVE_W;
  localparam logic [LIVE_W-1:0] RST_FLAGS = LIVE_W'(1) << B_HALT;

  logic [LIVE_W-1:0] set_vec;
  logic [LIVE_W-1:0] clr_vec;
  logic [LIVE_W-1:0] flags;
  logic              stop_fall;

  usbsts_evt_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_xfer_done (ev_xfer_done),
    .ev_xfer_err  (ev_xfer_err),
    .ev_short_pkt (ev_short_pkt),
    .td_ioc       (td_ioc),
    .td_spd       (td_spd),
    .ev_resume    (ev_resume),
    .ev_proc_err  (ev_proc_err),
    .ev_bus_err   (ev_bus_err),
    .run_stop     (run_stop),
    .suspend_on   (suspend_on),
    .stop_fall    (stop_fall),
    .set_vec      (set_vec)
  );

  assign clr_vec = sw_wr ? sw_wdata : '0;

  for (genvar b = 0; b < LIVE_W; b++) begin : g_flag
    usbsts_w1c_cell #(.RST_VAL(RST_FLAGS[b])) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[b]),
      .clr_i  (clr_vec[b]),
      .flag_o (flags[b])
    );
  end

  usbsts_irq_merge #(.GATED(GATED_W), .FORCED(2)) u_irq (
    .gated_flags  (flags[GATED_W-1:0]),
    .enables      (ien),
    .forced_flags ({flags[B_PERR], flags[B_HBE]}),
    .irq_o        (irq)
  );

  assign stop_req = flags[B_PERR] | flags[B_HBE];
  assign sts_word = {{RSV_W{1'b0}}, flags};

endmodule

// File: rtl/usbsts_unit_chk.sv
module usbsts_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_xfer_err,
  input logic        td_ioc,
  input logic        ev_resume,
  input logic        ev_proc_err,
  input logic        ev_bus_err,
  input logic        run_stop,
  input logic        suspend_on,
  input logic        sw_wr,
  input logic [5:0]  sw_wdata,
  input logic [15:0] sts_word,
  input logic        irq,
  input logic        stop_req
);

  a_r4_halt_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_stop) |=> sts_word[5]);

  a_r5_proc_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_proc_err |=> (sts_word[4] && stop_req && irq));

  a_r6_bus_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> (sts_word[3] && stop_req && irq));

  a_r7_resume_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_resume && !suspend_on && !sts_word[2]) |=> !sts_word[2]);

  a_r8_err_with_ioc: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer_err && td_ioc) |=> (sts_word[1] && sts_word[0]));

  a_r3_clear_bit1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_wdata[1] && !ev_xfer_err) |=> !sts_word[1]);

  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_wdata[4] && ev_proc_err) |=> sts_word[4]);

  a_r11_no_flags_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_word[4:0] == 5'd0) |-> !irq);

endmodule

bind usbsts_unit usbsts_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_xfer_err (ev_xfer_err),
  .td_ioc      (td_ioc),
  .ev_resume   (ev_resume),
  .ev_proc_err (ev_proc_err),
  .ev_bus_err  (ev_bus_err),
  .run_stop    (run_stop),
  .suspend_on  (suspend_on),
  .sw_wr       (sw_wr),
  .sw_wdata    (sw_wdata),
  .sts_word    (sts_word),
  .irq         (irq),
  .stop_req    (stop_req)
);

// File: tb/usbsts_unit_tb.sv
`timescale 1ns/1ps
module usbsts_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_xfer_done = 0, ev_xfer_err = 0, ev_short_pkt = 0;
  logic        td_ioc = 0, td_spd = 0, ev_resume = 0;
  logic        ev_proc_err = 0, ev_bus_err = 0;
  logic        run_stop = 0, suspend_on = 0;
  logic [2:0]  ien = 3'b000;
  logic        sw_wr = 0;
  logic [5:0]  sw_wdata = 6'd0;
  logic [15:0] sts_word;
  logic        irq, stop_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usbsts_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_xfer_done(ev_xfer_done), .ev_xfer_err(ev_xfer_err), .ev_short_pkt(ev_short_pkt),
    .td_ioc(td_ioc), .td_spd(td_spd), .ev_resume(ev_resume),
    .ev_proc_err(ev_proc_err), .ev_bus_err(ev_bus_err),
    .run_stop(run_stop), .suspend_on(suspend_on), .ien(ien),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sts_word(sts_word), .irq(irq), .stop_req(stop_req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic swclr(input logic [5:0] m);
    sw_wr = 1'b1; sw_wdata = m;
    step();
    sw_wr = 1'b0; sw_wdata = 6'd0;
  endtask

  function automatic logic exp_irq(input logic [5:0] f, input logic [2:0] en);
    return |(f[2:0] & en) | f[3] | f[4];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [5:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 sts", sts_word, 16'h0020);
    check("R1 irq/stop", {14'd0, irq, stop_req}, 16'd0);
    // R11: halted alone never interrupts
    ien = 3'b111;
    check("R11 halt no irq", {15'd0, irq}, 16'd0);
    // R3 write 0 leaves halted, write 1 clears it
    swclr(6'b011111);
    check("R3 zero bit kept", sts_word, 16'h0020);
    swclr(6'b100000);
    check("R3 clear halted", sts_word, 16'h0000);
    // R4: staying at 0 does not set; a fall sets
    step();
    check("R4 no set at 0", sts_word, 16'h0000);
    run_stop = 1'b1; step(); step();
    check("R4 running", sts_word, 16'h0000);
    run_stop = 1'b0; step();
    check("R4 fall sets halt", sts_word, 16'h0020);
    swclr(6'h3F);
    // R8/R9 exhaustive sweep over transfer events and descriptor flags
    for (int k = 0; k < 32; k++) begin
      logic d, x, s, io, sp;
      logic [15:0] ex;
      {d, x, s, io, sp} = 5'(k);
      ev_xfer_done = d; ev_xfer_err = x; ev_short_pkt = s; td_ioc = io; td_spd = sp;
      step();
      ev_xfer_done = 0; ev_xfer_err = 0; ev_short_pkt = 0; td_ioc = 0; td_spd = 0;
      ex = '0;
      ex[0] = ((d | x) & io) | (s & sp);
      ex[1] = x;
      check("R8 R9 sweep", sts_word, ex);
      check("R2 reserved", {6'd0, sts_word[15:6]}, 16'd0);
      swclr(6'h3F);
    end
    // R7 resume gating
    ev_resume = 1; suspend_on = 0; step(); ev_resume = 0;
    check("R7 ignored awake", sts_word, 16'h0000);
    suspend_on = 1; ev_resume = 1; step(); ev_resume = 0; suspend_on = 0;
    check("R7 set in suspend", sts_word, 16'h0004);
    swclr(6'h3F);
    // R11 enable sweep on gated flags
    for (int b = 0; b < 3; b++) begin
      for (int en = 0; en < 8; en++) begin
        ien = 3'(en);
        if (b == 0) begin ev_xfer_done = 1; td_ioc = 1; end
        if (b == 1) ev_xfer_err = 1;
        if (b == 2) begin ev_resume = 1; suspend_on = 1; end
        step();
        ev_xfer_done = 0; td_ioc = 0; ev_xfer_err = 0; ev_resume = 0; suspend_on = 0;
        e = 6'(1 << b);
        check("R11 gated irq", {15'd0, irq}, {15'd0, exp_irq(e, 3'(en))});
        step();
        check("R11 irq level held", {15'd0, irq}, {15'd0, exp_irq(e, 3'(en))});
        swclr(6'h3F);
        check("R11 irq drops", {15'd0, irq}, 16'd0);
      end
    end
    // R5 process error, all enables off
    ien = 3'b000;
    ev_proc_err = 1; step(); ev_proc_err = 0;
    check("R5 bit4", sts_word, 16'h0010);
    check("R5 stop/irq", {14'd0, irq, stop_req}, 16'h0003);
    swclr(6'h10);
    check("R5 stop released", {14'd0, irq, stop_req}, 16'd0);
    // R6 bus error
    ev_bus_err = 1; step(); ev_bus_err = 0;
    check("R6 bit3", sts_word, 16'h0008);
    check("R6 stop/irq", {14'd0, irq, stop_req}, 16'h0003);
    swclr(6'h08);
    check("R6 stop released", {15'd0, stop_req}, 16'd0);
    // R10 collisions on every flag
    sw_wr = 1; sw_wdata = 6'h3F;
    ev_proc_err = 1; ev_bus_err = 1; ev_xfer_err = 1; td_ioc = 1;
    ev_resume = 1; suspend_on = 1;
    step();
    sw_wr = 0; sw_wdata = 0; ev_proc_err = 0; ev_bus_err = 0; ev_xfer_err = 0;
    td_ioc = 0; ev_resume = 0; suspend_on = 0;
    check("R10 set wins", sts_word, 16'h001F);
    swclr(6'h3F);
    run_stop = 1; step();
    run_stop = 0; sw_wr = 1; sw_wdata = 6'h20; step();
    sw_wr = 0; sw_wdata = 0;
    check("R10 halt set wins", sts_word, 16'h0020);
    // R3 partial clear
    swclr(6'h1F);
    ev_xfer_err = 1; td_ioc = 1; ev_bus_err = 1; step();
    ev_xfer_err = 0; td_ioc = 0; ev_bus_err = 0;
    swclr(6'h02);
    check("R3 partial clear", sts_word, 16'h0029);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule